// File: doc/BRIEF.md
# Host Byte Packetizer with Clear-to-Send

This block sits between a host serial receiver and a radio transmit engine. Each byte the host sends is placed in a 192-entry ring buffer. The block then decides when the buffered bytes form a packet that can be handed to the transmitter. A packet is released on one of two conditions. The first is that the number of unreleased bytes reaches a programmable fill level (the MTU). The second is that an idle timer runs out. The idle timer is reloaded by every accepted byte and counts down on a one-millisecond tick input.

A released packet is announced with a `pkt_ready` level and a `pkt_len` value. The transmitter then pops exactly that many bytes, in arrival order, through a combinational read port. `pkt_ready` falls on the last pop. Bytes that arrive during this read are kept behind the packet. The `cts` output tells the host to stop sending. It is high when the buffer is full. It is also high when a release is due while the transmitter reports itself busy. Bytes offered while `cts` is high are dropped.

Top module: `host_packetizer`

## Requirements
- R1: After reset, `cts` and `pkt_ready` are low. The fill level is 64 and the idle timeout is 16 ticks: 64 bytes release at once, and a single byte releases after the 16th tick.
- R2: A byte is accepted when `rx_valid` is high and `cts` is low. Bytes leave through `rd_data` in the order they were accepted.
- R3: When the unreleased byte count reaches the fill level, with `tx_busy` low and no packet pending, `pkt_ready` rises on the next clock with `pkt_len` equal to the fill level.
- R4: Every accepted byte reloads the idle counter with the timeout setting, and each `ms_tick` decrements it. A byte and a tick in the same cycle reload the counter. When the counter reaches zero with bytes buffered, a packet of the buffered bytes is released.
- R5: A timeout setting of 0 turns the idle release off, so only the fill level releases a packet.
- R6: A packet carries at most fill-level bytes. Bytes beyond that stay buffered and are released by a later trigger.
- R7: `cts` is high whenever all 192 entries hold bytes.
- R8: While `tx_busy` is high, no packet is released. If a release is due during that time, `cts` is high.
- R9: A byte offered while `cts` is high is discarded and never reaches `rd_data`.
- R10: The fill-level setting written with `cfg_wr` is clamped to the range 1 to 128. A value of 0 acts as 1, and any value above 128 acts as 128.
- R11: `rd_en` removes nothing while `pkt_ready` is low. `pkt_ready` falls after exactly `pkt_len` pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Loads both settings below |
| cfg_mtu | input | 8 | Fill level that triggers a release (clamped 1..128) |
| cfg_idle_ms | input | 8 | Idle timeout in ticks; 0 turns the idle release off |
| rx_valid | input | 1 | Host byte strobe |
| rx_data | input | 8 | Host byte |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| tx_busy | input | 1 | Transmitter still sending the previous packet |
| rd_en | input | 1 | Pops one packet byte while `pkt_ready` is high |
| pkt_ready | output | 1 | A packet is ready to be read |
| pkt_len | output | 8 | Length of the ready packet |
| rd_data | output | 8 | Oldest buffered byte |
| cts | output | 1 | High: host must stop sending |

## Verification
Two functions can land on the same edge. The first is a host byte that arrives in the same cycle as a millisecond tick. The bench provokes this by letting the counter fall to 1 and then driving both strobes together. The result is judged by the full timeout of further ticks that must pass before the packet appears. The second is a packet launch that falls on the edge where the next host byte is written. A long stream crosses the fill level while bytes keep coming, and the read-out then has to show the first packet's bytes in order, with the later bytes left behind it.

// File: rtl/pktz_pkg.sv
package pktz_pkg;

  // Fill level as the block uses it: never below one, never above the cap.
  function automatic int clamp_mtu(input int v, input int cap);
    if (v < 1) return 1;
    if (v > cap) return cap;
    return v;
  endfunction

  // Bytes handed over by one release.
  function automatic int release_len(input int queued, input int mtu);
    return (queued < mtu) ? queued : mtu;
  endfunction

  // Ring index advance with a depth that need not be a power of two.
  function automatic int ring_next(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/pktz_ring.sv
module pktz_ring #(
  parameter int DW    = 8,
  parameter int DEPTH = 192,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full
);
  import pktz_pkg::*;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= PW'(ring_next(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(ring_next(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = mem[rd_ptr];
  assign full = (int'(count) == DEPTH);

endmodule

// File: rtl/pktz_idle_timer.sv
module pktz_idle_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          tick,
  input  logic          run,
  input  logic [TW-1:0] idle_val,
  output logic          expired
);
  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (reload) begin
      remain <= idle_val;
    end else if (tick && run && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  // A zero timeout disables the idle release.
  assign expired = (idle_val != '0) && (remain == '0);

endmodule

// File: rtl/pktz_release.sv
module pktz_release #(
  parameter int CW = 8,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trigger,
  input  logic          tx_busy,
  input  logic [CW-1:0] queued,
  input  logic [LW-1:0] mtu,
  input  logic          pop,
  output logic          pkt_ready,
  output logic [LW-1:0] pkt_len,
  output logic [LW-1:0] left
);
  import pktz_pkg::*;

  logic launch;
  assign launch = trigger && !tx_busy && !pkt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_ready <= 1'b0;
      pkt_len   <= '0;
      left      <= '0;
    end else if (launch) begin
      pkt_ready <= 1'b1;
      pkt_len   <= LW'(release_len(int'(queued), int'(mtu)));
      left      <= LW'(release_len(int'(queued), int'(mtu)));
    end else if (pop) begin
      left <= left - 1'b1;
      if (left == LW'(1)) pkt_ready <= 1'b0;
    end
  end

endmodule

// File: rtl/host_packetizer.sv
module host_packetizer #(
  parameter int DW       = 8,
  parameter int DEPTH    = 192,
  parameter int MTU_MAX  = 128,
  parameter int MTU_RST  = 64,
  parameter int CFGW     = 8,
  parameter int IDLE_RST = 16,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int LW      = $clog2(MTU_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [CFGW-1:0] cfg_mtu,
  input  logic [CFGW-1:0] cfg_idle_ms,
  input  logic            rx_valid,
  input  logic [DW-1:0]   rx_data,
  input  logic            ms_tick,
  input  logic            tx_busy,
  input  logic            rd_en,
  output logic            pkt_ready,
  output logic [LW-1:0]   pkt_len,
  output logic [DW-1:0]   rd_data,
  output logic            cts
);
  import pktz_pkg::*;

  logic [LW-1:0]   mtu_q;
  logic [CFGW-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mtu_q  <= LW'(MTU_RST);
      idle_q <= CFGW'(IDLE_RST);
    end else if (cfg_wr) begin
      mtu_q  <= LW'(clamp_mtu(int'(cfg_mtu), MTU_MAX));
      idle_q <= cfg_idle_ms;
    end
  end

  // Named internal events, also watched by the checker.
  logic          push, pop, full;
  logic [CW-1:0] count, queued;
  logic [LW-1:0] left;
  logic          has_data, fill_hit, idle_exp, idle_hit, trigger;

  assign push = rx_valid && !cts;
  assign pop  = rd_en && pkt_ready;

  pktz_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .din(rx_data), .pop(pop),
    .dout(rd_data), .count(count), .full(full)
  );

  assign queued   = count - CW'(left);
  assign has_data = (queued != '0);
  assign fill_hit = (int'(queued) >= int'(mtu_q));

  pktz_idle_timer #(.TW(CFGW)) u_timer (
    .clk(clk), .rst_n(rst_n), .reload(push), .tick(ms_tick),
    .run(has_data), .idle_val(idle_q), .expired(idle_exp)
  );

  assign idle_hit = idle_exp && has_data;
  assign trigger  = fill_hit || idle_hit;

  pktz_release #(.CW(CW), .LW(LW)) u_rel (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .tx_busy(tx_busy),
    .queued(queued), .mtu(mtu_q), .pop(pop),
    .pkt_ready(pkt_ready), .pkt_len(pkt_len), .left(left)
  );

  assign cts = full || (trigger && tx_busy);

endmodule

// File: rtl/pktz_chk.sv
module pktz_chk #(
  parameter int DEPTH = 192,
  parameter int CW    = 8,
  parameter int LW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rd_en,
  input logic          tx_busy,
  input logic          cts,
  input logic          pkt_ready,
  input logic [LW-1:0] pkt_len,
  input logic [LW-1:0] mtu_q,
  input logic [CW-1:0] count,
  input logic [CW-1:0] queued
);

  // R7
  full_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) == DEPTH) |-> cts);

  // R2
  capacity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R9
  dropped_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cts && !(rd_en && pkt_ready)) |=> count == $past(count));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !pkt_ready) |=> !pkt_ready);

  // R6
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_ready) |-> (pkt_len != '0 && pkt_len <= mtu_q));

  // R3
  fill_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_ready && !tx_busy && int'(queued) >= int'(mtu_q)) |=> pkt_ready);

  // R11
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_ready && rd_en && !rx_valid) |=> count == $past(count));

endmodule

bind host_packetizer pktz_chk #(.DEPTH(DEPTH), .CW(CW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rd_en(rd_en),
  .tx_busy(tx_busy), .cts(cts), .pkt_ready(pkt_ready), .pkt_len(pkt_len),
  .mtu_q(mtu_q), .count(count), .queued(queued)
);

// File: tb/sim_host_packetizer.sv
module sim_host_packetizer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_mtu = '0, cfg_idle_ms = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       ms_tick = 1'b0, tx_busy = 1'b0, rd_en = 1'b0;
  logic       pkt_ready, cts;
  logic [7:0] pkt_len, rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  host_packetizer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mtu(cfg_mtu),
    .cfg_idle_ms(cfg_idle_ms), .rx_valid(rx_valid), .rx_data(rx_data),
    .ms_tick(ms_tick), .tx_busy(tx_busy), .rd_en(rd_en),
    .pkt_ready(pkt_ready), .pkt_len(pkt_len), .rd_data(rd_data), .cts(cts)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // mtu, idle, bytes, ticks, expect ready, expect length
  localparam logic [47:0] VEC [7] = '{
    {8'd4,   8'd0, 8'd4,   8'd0,  8'd1, 8'd4},
    {8'd8,   8'd3, 8'd5,   8'd3,  8'd1, 8'd5},
    {8'd8,   8'd3, 8'd5,   8'd2,  8'd0, 8'd0},
    {8'd8,   8'd0, 8'd7,   8'd20, 8'd0, 8'd0},
    {8'd0,   8'd0, 8'd1,   8'd0,  8'd1, 8'd1},
    {8'd200, 8'd2, 8'd130, 8'd0,  8'd1, 8'd128},
    {8'd3,   8'd5, 8'd7,   8'd0,  8'd1, 8'd3}
  };

  function automatic string row_req(input int r);
    case (r)
      0: return "R3";
      1, 2: return "R4";
      3: return "R5";
      4, 5: return "R10";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rx_valid = 1'b0; ms_tick = 1'b0; rd_en = 1'b0;
    tx_busy = 1'b0; cfg_wr = 1'b0;
    clocks(2);
    rst_n = 1'b1;
    clocks(1);
  endtask

  task automatic set_cfg(input int mtu, input int idle);
    cfg_mtu = 8'(mtu); cfg_idle_ms = 8'(idle); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic send(input int val);
    rx_valid = 1'b1; rx_data = 8'(val);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tick();
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_pkt(input int n, input int base, input string req);
    for (int i = 0; i < n; i++) begin
      chk(req, int'(rd_data), (base + i) & 255);
      rd_en = 1'b1;
      @(negedge clk);
    end
    rd_en = 1'b0;
  endtask

  initial begin
    do_reset();

    // R1: reset state
    chk("R1 cts", int'(cts), 0);
    chk("R1 pkt_ready", int'(pkt_ready), 0);

    // Vector table: R3 R4 R5 R6 R10 (R2 via data order)
    for (int r = 0; r < 7; r++) begin
      do_reset();
      set_cfg(int'(VEC[r][47:40]), int'(VEC[r][39:32]));
      for (int b = 0; b < int'(VEC[r][31:24]); b++) send(r * 40 + b);
      for (int t = 0; t < int'(VEC[r][23:16]); t++) tick();
      clocks(2);
      chk(row_req(r), int'(pkt_ready), int'(VEC[r][15:8]));
      if (VEC[r][15:8] != 0) begin
        chk(row_req(r), int'(pkt_len), int'(VEC[r][7:0]));
        read_pkt(int'(VEC[r][7:0]), r * 40, "R2");
      end
    end

    // R1: default fill level 64
    do_reset();
    for (int b = 0; b < 63; b++) send(b);
    clocks(2);
    chk("R1 63 bytes", int'(pkt_ready), 0);
    send(63);
    clocks(1);
    chk("R1 64 bytes", int'(pkt_ready), 1);
    chk("R1 len", int'(pkt_len), 64);

    // R1: default timeout 16 ticks
    do_reset();
    send(5);
    for (int t = 0; t < 15; t++) tick();
    chk("R1 15 ticks", int'(pkt_ready), 0);
    tick();
    clocks(1);
    chk("R1 16 ticks", int'(pkt_ready), 1);
    chk("R1 len", int'(pkt_len), 1);

    // R4: byte and tick together reload the counter
    do_reset();
    set_cfg(8, 4);
    send(1);
    for (int t = 0; t < 3; t++) tick();
    rx_valid = 1'b1; rx_data = 8'd2; ms_tick = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; ms_tick = 1'b0;
    clocks(1);
    for (int t = 0; t < 3; t++) tick();
    chk("R4 reload wins", int'(pkt_ready), 0);
    tick();
    clocks(1);
    chk("R4 after reload", int'(pkt_ready), 1);
    chk("R4 len", int'(pkt_len), 2);
    read_pkt(2, 1, "R4 data");

    // R8: busy transmitter holds the release and raises cts
    do_reset();
    set_cfg(4, 0);
    tx_busy = 1'b1;
    for (int b = 0; b < 4; b++) send(8'h50 + b);
    clocks(1);
    chk("R8 cts", int'(cts), 1);
    chk("R8 no launch", int'(pkt_ready), 0);
    send(8'h99);  // R9: dropped
    tx_busy = 1'b0;
    clocks(1);
    chk("R8 cts low", int'(cts), 0);
    chk("R8 launch", int'(pkt_ready), 1);
    chk("R8 len", int'(pkt_len), 4);
    read_pkt(4, 8'h50, "R8 data");
    clocks(2);
    chk("R9 nothing left", int'(pkt_ready), 0);

    // R7 / R9 / R11 / R6: fill the whole buffer
    do_reset();
    set_cfg(128, 0);
    for (int b = 0; b < 192; b++) send(b);
    chk("R7 full cts", int'(cts), 1);
    chk("R6 first len", int'(pkt_len), 128);
    send(8'hEE);  // R9: dropped
    read_pkt(128, 0, "R6 data");
    chk("R11 ready falls", int'(pkt_ready), 0);
    chk("R7 room cts", int'(cts), 0);
    set_cfg(64, 0);
    clocks(1);
    chk("R6 rest", int'(pkt_ready), 1);
    chk("R6 rest len", int'(pkt_len), 64);
    read_pkt(64, 128, "R9 order");
    set_cfg(1, 0);
    clocks(2);
    chk("R9 dropped", int'(pkt_ready), 0);

    // R11: rd_en without a packet removes nothing
    do_reset();
    set_cfg(8, 0);
    send(8'h11);
    send(8'h12);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R11 idle read", int'(pkt_ready), 0);
    set_cfg(2, 0);
    clocks(1);
    chk("R11 launch", int'(pkt_ready), 1);
    chk("R11 len", int'(pkt_len), 2);
    read_pkt(2, 8'h11, "R11 data");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule